// File: doc/BRIEF.md
# Lockable configuration register bank

This block is a small bank of byte-wide configuration registers that sits behind a serial slave's register port. Three of the registers hold settings and are protected: discharge settings at address 5, charge settings at address 6 and feature settings at address 7. A fourth register at address 8 holds one unlock bit for each protected register. When reset is asserted, every register clears to zero. All protected registers are therefore locked after power-up.

Software first sets the unlock bit of one register in register 8. It then writes that register, and it may clear the unlock bit afterwards to lock the register again. A write to a locked register does not change it, and the block raises a one-cycle rejected-write flag. Reads are never restricted. The register contents are also driven continuously on parallel outputs for the logic that uses them.

Top module: `cfg_regfile_lock`

## Requirements
- R1: While rst_ni is low, every register, rdata_o and wr_reject_o are zero.
- R2: Bit N of register 8 unlocks the protected register at address N, for N in 5, 6 and 7. A write to address N while that bit is 1 loads wdata_i into the register. The new value shows on prot_cfg_o after the next rising edge. Address 5 is bits 7:0 of prot_cfg_o, address 6 is bits 15:8 and address 7 is bits 23:16.
- R3: A write to address 5, 6 or 7 while its unlock bit is 0 leaves the register unchanged. wr_reject_o is 1 for exactly the cycle that follows that edge.
- R4: Register 8 accepts every write. Bits 7:5 take wdata_i, and bits 4:0 are always stored and read as 0. The register is visible on wen_o.
- R5: Writing a 0 to an unlock bit locks its register again. Later writes to that register are rejected as R3 describes.
- R6: When rd_en_i is 1 on an edge, rdata_o takes the value of the register at addr_i, whatever the unlock bits are. Unmapped addresses read as 0. When rd_en_i is 0, rdata_o holds its value.
- R7: A write to an address other than 5 to 8 changes no register and does not raise wr_reject_o.
- R8: wr_reject_o is 0 after any edge that has no rejected write, including accepted writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| prot_cfg_o | output | 24 | Protected registers, address 5 in the low byte |
| wen_o | output | 8 | Unlock register (address 8) |
| wr_reject_o | output | 1 | One-cycle pulse after a write to a locked register |

## Verification
The bench sweeps every 16-address write under all eight unlock patterns. This catches a design that maps an unlock bit to the wrong register, that lets one unlock bit open its neighbours, or that raises the rejected-write flag for unmapped addresses. After each pattern it reads back every address. This exposes a read path that is gated by the lock bits, and low bits of register 8 that keep written ones. A relock sequence shows whether a cleared unlock bit really blocks writes again. An idle check after a read catches read data that does not hold when no read is requested.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 4;
  localparam int NUM_PROT  = 3;
  localparam int PROT_BASE = 5;  // first protected address
  localparam int WEN_ADDR  = 8;  // unlock register address
  localparam int WEN_LSB   = 5;  // unlock bit of register PROT_BASE
endpackage

// File: rtl/cfg_lock_decode.sv
module cfg_lock_decode #(
  parameter int ADDR_W    = 4,
  parameter int NUM_PROT  = 3,
  parameter int PROT_BASE = 5,
  parameter int WEN_ADDR  = 8
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_PROT-1:0] prot_hit_o,
  output logic                wen_hit_o
);
  for (genvar k = 0; k < NUM_PROT; k++) begin : g_hit
    assign prot_hit_o[k] = (addr_i == ADDR_W'(PROT_BASE + k));
  end
  assign wen_hit_o = (addr_i == ADDR_W'(WEN_ADDR));
endmodule

// File: rtl/cfg_lock_reg.sv
module cfg_lock_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              unlock_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o,
  output logic              reject_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q_o <= '0;
    else if (we_i && unlock_i) q_o <= wdata_i;
  end

  assign reject_o = we_i & ~unlock_i;

  p_locked_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !unlock_i) |=> $stable(q_o));
  p_unlocked_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && unlock_i) |=> (q_o == $past(wdata_i)));
  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/cfg_lock_wen.sv
module cfg_lock_wen #(
  parameter int DATA_W   = 8,
  parameter int NUM_PROT = 3,
  parameter int WEN_LSB  = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   q_o,
  output logic [NUM_PROT-1:0] unlock_o
);
  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(((1 << NUM_PROT) - 1) << WEN_LSB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i & KEEP_MASK;
  end

  assign unlock_o = q_o[WEN_LSB +: NUM_PROT];

  p_wen_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o[WEN_LSB +: NUM_PROT] == $past(wdata_i[WEN_LSB +: NUM_PROT])));
  p_wen_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/cfg_regfile_lock.sv
module cfg_regfile_lock
  import cfg_lock_pkg::*;
#(
  parameter int P_DATA_W    = DATA_W,
  parameter int P_ADDR_W    = ADDR_W,
  parameter int P_NUM_PROT  = NUM_PROT,
  parameter int P_PROT_BASE = PROT_BASE,
  parameter int P_WEN_ADDR  = WEN_ADDR,
  parameter int P_WEN_LSB   = WEN_LSB
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic                           rd_en_i,
  input  logic [P_ADDR_W-1:0]            addr_i,
  input  logic [P_DATA_W-1:0]            wdata_i,
  output logic [P_DATA_W-1:0]            rdata_o,
  output logic [P_NUM_PROT*P_DATA_W-1:0] prot_cfg_o,
  output logic [P_DATA_W-1:0]            wen_o,
  output logic                           wr_reject_o
);
  logic [P_NUM_PROT-1:0] prot_hit, unlock, prot_rej;
  logic                  wen_hit;
  logic [P_DATA_W-1:0]   prot_q [P_NUM_PROT];
  logic [P_DATA_W-1:0]   rd_mux;

  cfg_lock_decode #(
    .ADDR_W(P_ADDR_W), .NUM_PROT(P_NUM_PROT),
    .PROT_BASE(P_PROT_BASE), .WEN_ADDR(P_WEN_ADDR)
  ) u_dec (
    .addr_i(addr_i), .prot_hit_o(prot_hit), .wen_hit_o(wen_hit)
  );

  cfg_lock_wen #(
    .DATA_W(P_DATA_W), .NUM_PROT(P_NUM_PROT), .WEN_LSB(P_WEN_LSB)
  ) u_wen (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en_i & wen_hit),
    .wdata_i(wdata_i), .q_o(wen_o), .unlock_o(unlock)
  );

  for (genvar k = 0; k < P_NUM_PROT; k++) begin : g_prot
    cfg_lock_reg #(.DATA_W(P_DATA_W)) u_reg (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en_i & prot_hit[k]),
      .unlock_i(unlock[k]), .wdata_i(wdata_i),
      .q_o(prot_q[k]), .reject_o(prot_rej[k])
    );
    assign prot_cfg_o[k*P_DATA_W +: P_DATA_W] = prot_q[k];
  end

  always_comb begin
    rd_mux = '0;
    if (wen_hit) rd_mux = wen_o;
    for (int k = 0; k < P_NUM_PROT; k++)
      if (prot_hit[k]) rd_mux = prot_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o     <= '0;
      wr_reject_o <= 1'b0;
    end else begin
      if (rd_en_i) rdata_o <= rd_mux;
      wr_reject_o <= |prot_rej;
    end
  end

  p_reject_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && |(prot_hit & ~wen_o[P_WEN_LSB +: P_NUM_PROT])) |=> wr_reject_o);
  p_unmapped_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !(|prot_hit)) |=> !wr_reject_o);
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !wr_reject_o);
  p_wen_low_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && wen_hit) |=> (rdata_o[P_WEN_LSB-1:0] == '0));
  p_rdata_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/cfg_regfile_lock_test.sv
module cfg_regfile_lock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, wen;
  logic [23:0] prot_cfg;
  logic        reject;

  int errors = 0;
  int checks = 0;
  logic [7:0] m [16];

  always #4 clk = ~clk;

  cfg_regfile_lock uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .prot_cfg_o(prot_cfg),
    .wen_o(wen), .wr_reject_o(reject)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_state(string tag);
    chk({tag, " prot_cfg"}, 32'(prot_cfg), 32'({m[7], m[6], m[5]}));
    chk({tag, " wen"}, 32'(wen), 32'(m[8]));
  endtask

  // called at a negedge; returns at the next negedge
  task automatic do_write(logic [3:0] a, logic [7:0] d, string tag);
    logic exp_rej;
    exp_rej = (a >= 5 && a <= 7) && !m[8][a];
    if (a >= 5 && a <= 7 && m[8][a]) m[a] = d;
    if (a == 8) m[8] = d & 8'hE0;
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk({tag, " reject"}, 32'(reject), 32'(exp_rej));
    chk_state(tag);
  endtask

  task automatic do_read(logic [3:0] a, string tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, 32'(rdata), 32'(m[a]));
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m[i] = '0;
    wr_en = 1'b1; rd_en = 1'b1; addr = 4'd5; wdata = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", 32'(rdata), 0);
    chk("R1 reset reject", 32'(reject), 0);
    chk_state("R1 reset");
    wr_en = 1'b0; rd_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle reject", 32'(reject), 0);

    // R2 R3 R4 R7 sweep over every unlock pattern and address
    for (int p = 0; p < 8; p++) begin
      do_write(4'd8, {3'(p), 5'b10101}, "R4 wen write");
      for (int a = 0; a < 16; a++)
        do_write(4'(a), 8'((a * 17) ^ (p * 37) ^ 8'h5A), "R2/R3/R7 sweep");
      for (int a = 0; a < 16; a++)
        do_read(4'(a), "R6 readback");
      chk("R8 after reads reject", 32'(reject), 0);
    end

    // R5 relock
    do_write(4'd8, 8'hFF, "R4 unlock all");
    do_write(4'd5, 8'hC3, "R2 load 5");
    do_write(4'd6, 8'h3C, "R2 load 6");
    do_write(4'd7, 8'h99, "R2 load 7");
    do_write(4'd8, 8'h00, "R5 relock");
    do_write(4'd5, 8'h11, "R5 locked 5");
    do_write(4'd6, 8'h22, "R5 locked 6");
    do_write(4'd7, 8'h33, "R5 locked 7");
    @(negedge clk);
    chk("R8 idle after reject", 32'(reject), 0);

    // R6 hold when no read
    do_read(4'd7, "R6 read 7");
    addr = 4'd5;
    repeat (2) @(negedge clk);
    chk("R6 rdata hold", 32'(rdata), 32'(m[7]));
    do_read(4'd8, "R6 read locked wen");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule